// File: doc/BRIEF.md
# Receive FIFO Read Unpacker

This block is the host-facing read side of a receive buffer. It has three queues. The first holds packet data words. The second holds one word count per packet. The third holds one status word per packet. A write-side agent pushes a packet's data words one at a time. It then commits the packet by giving its byte length and its address-class flags. The commit places a word count in the length queue and a status word in the status queue.

On the read side, the host pulls words one request at a time. When no packet is in progress, the next request starts one. It loads the packet's word count, a host-programmed number of leading zero words and a trailing zero-pad count. Reads then return the leading zeros, the packet data in order, and the pad zeros. The pad count brings the total number of words read for the packet up to a chosen alignment.

A skip command drops whatever is left of the current packet. If no packet is in progress, it drops the whole next packet. A dump command empties all three queues. A read with nothing to return raises a sticky error. A level output shows when the status queue holds more entries than a threshold.

Top module: `rx_unpack`

## Requirements
- R1: When a read or skip arrives with no packet in progress and the length queue is not empty, the head count is taken as the packet's data word count. The leading zero count is taken from `cfg_lead` as it is at that moment.
- R2: Reads of a packet return, in order: `cfg_lead` zero words, then the data words in the order they were pushed, then the pad zero words. `rd_data` is updated at the clock edge that samples `rd_req`.
- R3: The pad count is fixed when the packet starts. With `cfg_align` = 1, leading plus data plus pad words is a multiple of 4. With `cfg_align` = 2, it is a multiple of 8. With `cfg_align` = 0 or 3, there is no pad.
- R4: A read with no packet in progress and an empty length queue returns zero and sets `rx_err`. `rx_err` stays set until `err_clr` is pulsed.
- R5: A commit queues a word count of ceil(`pkt_bytes`/4) + 1. The extra word is the 4-byte CRC. The write side pushes exactly that many data words before the commit.
- R6: The status word has `pkt_bytes`+4 in bits 29:16. Bit 13 is set for broadcast. Bit 10 is set for multicast when the packet is not broadcast. Bit 30 is set for a filter miss. All other bits are zero.
- R7: A skip clears the remaining leading and pad counts and discards the remaining data words of the current packet. If no packet is in progress, it starts the next packet and discards all of it. It does not change `rd_data` and does not set `rx_err`.
- R8: A dump empties the data, length and status queues and ends any packet in progress. A read after a dump is an underflow.
- R9: `st_level` is high exactly when `stat_words` is greater than `st_thresh`.
- R10: A status pop on an empty status queue leaves `st_data` and `stat_words` unchanged. A pop on a non-empty queue returns the oldest status word.
- R11: The data queue pointers wrap at `DDEPTH`, which need not be a power of two. Data order is kept across the wrap.
- R12: After reset, `rd_data`, `st_data` and `rx_err` are zero, both counts are zero, and no packet is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_lead | input | 3 | Leading zero words per packet |
| cfg_align | input | 2 | End alignment code |
| st_thresh | input | 8 | Status level threshold |
| wr_en | input | 1 | Push one data word |
| wr_word | input | DW | Data word to push |
| pkt_done | input | 1 | Commit a packet |
| pkt_bytes | input | BW | Committed packet byte length |
| pkt_bcast | input | 1 | Committed packet is broadcast |
| pkt_mcast | input | 1 | Committed packet is multicast |
| pkt_miss | input | 1 | Committed packet failed the address filter |
| rd_req | input | 1 | Host read request |
| rd_data | output | DW | Word returned by the last read |
| skip_req | input | 1 | Discard rest of packet |
| dump_req | input | 1 | Empty all queues |
| st_pop | input | 1 | Pop one status word |
| st_data | output | 32 | Last popped status word |
| err_clr | input | 1 | Clear the underflow flag |
| rx_err | output | 1 | Sticky underflow flag |
| st_level | output | 1 | Status count above threshold |
| data_words | output | DCW | Data queue occupancy |
| stat_words | output | QCW | Status queue occupancy |

## Verification
The bench works the pad arithmetic at each alignment code with lead and size values that do not already fit the alignment. It also reads on into the next packet after the pad. A pad off by one would either return a data word too early or insert a stray zero.

The skip is exercised in the middle of the leading zeros, in the middle of the data, and with no packet in progress. A skip that forgot to start the next packet, or advanced the read pointer by the wrong amount, shows up as a wrong occupancy or a wrong next word.

Several packets are streamed through a data queue whose depth is not a power of two. A pointer that wraps at a power of two would return stale words. A pop on an empty status queue is also checked, to catch a design that moves the pointer or clears the held word.

// File: rtl/rx_unpack.sv
module rx_unpack #(
  parameter int DW     = 32,
  parameter int DDEPTH = 48,
  parameter int QDEPTH = 8,
  parameter int BW     = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        cfg_lead,
  input  logic [1:0]        cfg_align,
  input  logic [7:0]        st_thresh,
  input  logic              wr_en,
  input  logic [DW-1:0]     wr_word,
  input  logic              pkt_done,
  input  logic [BW-1:0]     pkt_bytes,
  input  logic              pkt_bcast,
  input  logic              pkt_mcast,
  input  logic              pkt_miss,
  input  logic              rd_req,
  output logic [DW-1:0]     rd_data,
  input  logic              skip_req,
  input  logic              dump_req,
  input  logic              st_pop,
  output logic [31:0]       st_data,
  input  logic              err_clr,
  output logic              rx_err,
  output logic              st_level,
  output logic [$clog2(DDEPTH+1)-1:0] data_words,
  output logic [$clog2(QDEPTH+1)-1:0] stat_words
);
  localparam int DAW = $clog2(DDEPTH);
  localparam int DCW = $clog2(DDEPTH+1);
  localparam int QAW = $clog2(QDEPTH);
  localparam int QCW = $clog2(QDEPTH+1);
  localparam int LW  = BW - 1;

  logic [DW-1:0] d_mem [DDEPTH];
  logic [LW-1:0] l_mem [QDEPTH];
  logic [31:0]   s_mem [QDEPTH];

  logic [DAW-1:0] d_head, d_tail;
  logic [DCW-1:0] d_cnt;
  logic [QAW-1:0] l_head, l_tail, s_head, s_tail;
  logic [QCW-1:0] l_cnt, s_cnt;
  logic [2:0]     lead_left, pad_left;
  logic [LW-1:0]  size_left;

  function automatic logic [QAW-1:0] q_inc(input logic [QAW-1:0] p);
    return (p == QAW'(QDEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  function automatic logic [DAW-1:0] d_inc(input logic [DAW-1:0] p);
    return (p == DAW'(DDEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  wire busy     = (lead_left != 0) || (size_left != 0) || (pad_left != 0);
  wire start    = !busy && (l_cnt != 0);
  wire act_skip = skip_req && !dump_req;
  wire act_rd   = rd_req && !dump_req && !skip_req;
  wire l_pop    = (act_skip || act_rd) && start;

  wire          push_ok   = wr_en && !dump_req && (d_cnt != DCW'(DDEPTH));
  wire          commit_ok = pkt_done && !dump_req &&
                            (l_cnt != QCW'(QDEPTH)) && (s_cnt != QCW'(QDEPTH));
  wire          s_pop_ok  = st_pop && !dump_req && (s_cnt != 0);

  wire [BW:0]   wtmp    = {1'b0, pkt_bytes} + (BW+1)'(3);
  wire [LW-1:0] words   = wtmp[BW:2] + LW'(1);
  wire [15:0]   len4    = 16'(pkt_bytes) + 16'd4;
  wire [31:0]   st_word = {len4, 16'h0000}
                        | (32'(pkt_miss) << 30)
                        | (32'(pkt_bcast) << 13)
                        | (32'(pkt_mcast & ~pkt_bcast) << 10);

  wire [LW:0]   nsum  = {1'b0, l_mem[l_head]} + (LW+1)'(cfg_lead);
  wire [LW:0]   nneg  = -nsum;
  wire [2:0]    pad_new = (cfg_align == 2'd1) ? {1'b0, nneg[1:0]} :
                          (cfg_align == 2'd2) ? nneg[2:0] : 3'd0;

  wire [2:0]    ld_lead = start ? cfg_lead       : lead_left;
  wire [LW-1:0] ld_size = start ? l_mem[l_head]  : size_left;
  wire [2:0]    ld_pad  = start ? pad_new        : pad_left;

  logic [2:0]    lead_n, pad_n;
  logic [LW-1:0] size_n, pop_n;
  logic [DW-1:0] rd_out;
  logic          uflow;

  always_comb begin
    lead_n = lead_left;
    size_n = size_left;
    pad_n  = pad_left;
    pop_n  = '0;
    rd_out = '0;
    uflow  = 1'b0;
    if (act_skip) begin
      lead_n = '0;
      size_n = '0;
      pad_n  = '0;
      pop_n  = ld_size;
    end else if (act_rd) begin
      lead_n = ld_lead;
      size_n = ld_size;
      pad_n  = ld_pad;
      if (ld_lead != 0) begin
        lead_n = ld_lead - 3'd1;
      end else if (ld_size != 0) begin
        size_n = ld_size - LW'(1);
        pop_n  = LW'(1);
        rd_out = d_mem[d_head];
      end else if (ld_pad != 0) begin
        pad_n = ld_pad - 3'd1;
      end else begin
        uflow = 1'b1;
      end
    end
  end

  logic [LW:0] hsum;
  always_comb begin
    hsum = (LW+1)'(d_head) + (LW+1)'(pop_n);
    if (hsum >= (LW+1)'(DDEPTH)) hsum = hsum - (LW+1)'(DDEPTH);
  end

  always_ff @(posedge clk) begin
    if (push_ok)   d_mem[d_tail] <= wr_word;
    if (commit_ok) begin
      l_mem[l_tail] <= words;
      s_mem[s_tail] <= st_word;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      d_head <= '0; d_tail <= '0; d_cnt <= '0;
      l_head <= '0; l_tail <= '0; l_cnt <= '0;
      s_head <= '0; s_tail <= '0; s_cnt <= '0;
      lead_left <= '0; size_left <= '0; pad_left <= '0;
    end else if (dump_req) begin
      d_head <= '0; d_tail <= '0; d_cnt <= '0;
      l_head <= '0; l_tail <= '0; l_cnt <= '0;
      s_head <= '0; s_tail <= '0; s_cnt <= '0;
      lead_left <= '0; size_left <= '0; pad_left <= '0;
    end else begin
      lead_left <= lead_n;
      size_left <= size_n;
      pad_left  <= pad_n;
      d_head    <= DAW'(hsum);
      if (push_ok) d_tail <= d_inc(d_tail);
      d_cnt     <= d_cnt + DCW'(push_ok) - DCW'(pop_n);
      if (l_pop)     l_head <= q_inc(l_head);
      if (commit_ok) l_tail <= q_inc(l_tail);
      l_cnt     <= l_cnt + QCW'(commit_ok) - QCW'(l_pop);
      if (s_pop_ok)  s_head <= q_inc(s_head);
      if (commit_ok) s_tail <= q_inc(s_tail);
      s_cnt     <= s_cnt + QCW'(commit_ok) - QCW'(s_pop_ok);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data <= '0;
      st_data <= '0;
      rx_err  <= 1'b0;
    end else begin
      if (act_rd)   rd_data <= rd_out;
      if (s_pop_ok) st_data <= s_mem[s_head];
      if (uflow)        rx_err <= 1'b1;
      else if (err_clr) rx_err <= 1'b0;
    end
  end

  assign st_level   = (32'(s_cnt) > 32'(st_thresh));
  assign data_words = d_cnt;
  assign stat_words = s_cnt;
endmodule

// File: rtl/rx_unpack_chk.sv
module rx_unpack_chk #(
  parameter int DDEPTH = 48,
  parameter int LW     = 10,
  parameter int DCW    = 6,
  parameter int QCW    = 4,
  parameter int DW     = 32
) (
  input logic           clk,
  input logic           rst_n,
  input logic           rd_req,
  input logic           skip_req,
  input logic           dump_req,
  input logic           st_pop,
  input logic [DW-1:0]  rd_data,
  input logic           rx_err,
  input logic [31:0]    st_data,
  input logic [DCW-1:0] data_words,
  input logic [QCW-1:0] stat_words,
  input logic [QCW-1:0] l_cnt,
  input logic [2:0]     lead_left,
  input logic [LW-1:0]  size_left,
  input logic [2:0]     pad_left
);
  wire plain_rd = rd_req && !skip_req && !dump_req;
  wire idle     = (lead_left == 0) && (size_left == 0) && (pad_left == 0);

  AST_LEAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (plain_rd && lead_left != 0) |=> (rd_data == '0));                          // R2
  AST_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (plain_rd && idle && l_cnt == 0) |=> rx_err);                               // R4
  AST_SKIP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (skip_req && !dump_req) |=> (lead_left == 0 && size_left == 0 && pad_left == 0)); // R7
  AST_DUMP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    dump_req |=> (data_words == 0 && stat_words == 0 && l_cnt == 0));           // R8
  AST_STAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (st_pop && stat_words == 0 && !dump_req) |=> $stable(st_data));             // R10
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(data_words) <= DDEPTH));                                               // R11
endmodule

bind rx_unpack rx_unpack_chk #(
  .DDEPTH(DDEPTH), .LW(LW), .DCW(DCW), .QCW(QCW), .DW(DW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .skip_req(skip_req),
  .dump_req(dump_req), .st_pop(st_pop), .rd_data(rd_data), .rx_err(rx_err),
  .st_data(st_data), .data_words(data_words), .stat_words(stat_words),
  .l_cnt(l_cnt), .lead_left(lead_left), .size_left(size_left), .pad_left(pad_left)
);

// File: tb/sim_rx_unpack.sv
module sim_rx_unpack;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  cfg_lead = '0;
  logic [1:0]  cfg_align = '0;
  logic [7:0]  st_thresh = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_word = '0;
  logic        pkt_done = 1'b0;
  logic [10:0] pkt_bytes = '0;
  logic        pkt_bcast = 1'b0, pkt_mcast = 1'b0, pkt_miss = 1'b0;
  logic        rd_req = 1'b0, skip_req = 1'b0, dump_req = 1'b0;
  logic        st_pop = 1'b0, err_clr = 1'b0;
  logic [31:0] rd_data, st_data;
  logic        rx_err, st_level;
  logic [5:0]  data_words;
  logic [3:0]  stat_words;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  rx_unpack u0 (
    .clk(clk), .rst_n(rst_n), .cfg_lead(cfg_lead), .cfg_align(cfg_align),
    .st_thresh(st_thresh), .wr_en(wr_en), .wr_word(wr_word),
    .pkt_done(pkt_done), .pkt_bytes(pkt_bytes), .pkt_bcast(pkt_bcast),
    .pkt_mcast(pkt_mcast), .pkt_miss(pkt_miss), .rd_req(rd_req),
    .rd_data(rd_data), .skip_req(skip_req), .dump_req(dump_req),
    .st_pop(st_pop), .st_data(st_data), .err_clr(err_clr), .rx_err(rx_err),
    .st_level(st_level), .data_words(data_words), .stat_words(stat_words)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic push_pkt(input int bytes, input logic [31:0] base,
                          input logic bc, input logic mc, input logic ms);
    int nw = (bytes + 3) / 4 + 1;
    for (int i = 0; i < nw; i++) begin
      @(negedge clk); wr_en = 1'b1; wr_word = base + 32'(i);
    end
    @(negedge clk); wr_en = 1'b0;
    pkt_done = 1'b1; pkt_bytes = 11'(bytes);
    pkt_bcast = bc; pkt_mcast = mc; pkt_miss = ms;
    @(negedge clk); pkt_done = 1'b0; pkt_bcast = 1'b0; pkt_mcast = 1'b0; pkt_miss = 1'b0;
  endtask

  task automatic rd_chk(input logic [31:0] exp, input string tag);
    @(negedge clk); rd_req = 1'b1;
    @(negedge clk); rd_req = 1'b0;
    chk(rd_data, exp, tag);
  endtask

  task automatic pulse_dump();
    @(negedge clk); dump_req = 1'b1; err_clr = 1'b1;
    @(negedge clk); dump_req = 1'b0; err_clr = 1'b0;
  endtask

  task automatic pulse_skip();
    @(negedge clk); skip_req = 1'b1;
    @(negedge clk); skip_req = 1'b0;
  endtask

  task automatic pop_status(input logic [31:0] exp, input string tag);
    @(negedge clk); st_pop = 1'b1;
    @(negedge clk); st_pop = 1'b0;
    chk(st_data, exp, tag);
  endtask

  task automatic t_reset();
    chk(rd_data, 32'h0, "R12 rd_data");
    chk(st_data, 32'h0, "R12 st_data");
    chk(32'(rx_err), 32'h0, "R12 rx_err");
    chk(32'(data_words), 32'h0, "R12 data_words");
    chk(32'(stat_words), 32'h0, "R12 stat_words");
    chk(32'(st_level), 32'h0, "R12 st_level");
  endtask

  task automatic t_basic();
    pulse_dump();
    cfg_lead = 3'd2; cfg_align = 2'd0;
    push_pkt(8, 32'hA000_0000, 1'b0, 1'b0, 1'b0);
    chk(32'(data_words), 32'd3, "R5 word count 8 bytes");
    rd_chk(32'h0, "R1 lead 0");
    rd_chk(32'h0, "R2 lead 1");
    rd_chk(32'hA000_0000, "R2 data 0");
    rd_chk(32'hA000_0001, "R2 data 1");
    rd_chk(32'hA000_0002, "R2 data 2");
    chk(32'(rx_err), 32'h0, "R4 no error yet");
    rd_chk(32'h0, "R4 underflow data");
    chk(32'(rx_err), 32'h1, "R4 error set");
    @(negedge clk); err_clr = 1'b1;
    @(negedge clk); err_clr = 1'b0;
    chk(32'(rx_err), 32'h0, "R4 error cleared");
  endtask

  task automatic t_align();
    pulse_dump();
    cfg_lead = 3'd1; cfg_align = 2'd1;
    push_pkt(9, 32'hB000_0000, 1'b0, 1'b0, 1'b0);
    rd_chk(32'h0, "R3 a1 lead");
    for (int i = 0; i < 4; i++) rd_chk(32'hB000_0000 + 32'(i), "R3 a1 data");
    for (int i = 0; i < 3; i++) rd_chk(32'h0, "R3 a1 pad");
    chk(32'(rx_err), 32'h0, "R3 a1 pad no error");
    rd_chk(32'h0, "R3 a1 end");
    chk(32'(rx_err), 32'h1, "R3 a1 pad exhausted");

    pulse_dump();
    cfg_lead = 3'd0; cfg_align = 2'd2;
    push_pkt(4, 32'hC000_0000, 1'b0, 1'b0, 1'b0);
    push_pkt(20, 32'hC100_0000, 1'b0, 1'b0, 1'b0);
    rd_chk(32'hC000_0000, "R3 a2 p0");
    rd_chk(32'hC000_0001, "R3 a2 p1");
    for (int i = 0; i < 6; i++) rd_chk(32'h0, "R3 a2 pad6");
    for (int i = 0; i < 6; i++) rd_chk(32'hC100_0000 + 32'(i), "R3 a2 q");
    rd_chk(32'h0, "R3 a2 pad2 0");
    rd_chk(32'h0, "R3 a2 pad2 1");
    chk(32'(rx_err), 32'h0, "R3 a2 no error");

    pulse_dump();
    cfg_align = 2'd3;
    push_pkt(4, 32'hD000_0000, 1'b0, 1'b0, 1'b0);
    push_pkt(4, 32'hD100_0000, 1'b0, 1'b0, 1'b0);
    rd_chk(32'hD000_0000, "R3 a3 r0");
    rd_chk(32'hD000_0001, "R3 a3 r1");
    rd_chk(32'hD100_0000, "R3 a3 no pad");
  endtask

  task automatic t_status();
    pulse_dump();
    st_thresh = 8'd1;
    push_pkt(14, 32'hE000_0000, 1'b1, 1'b0, 1'b0);
    push_pkt(20, 32'hE100_0000, 1'b0, 1'b1, 1'b1);
    push_pkt(5,  32'hE200_0000, 1'b1, 1'b1, 1'b0);
    chk(32'(stat_words), 32'd3, "R6 three statuses");
    chk(32'(st_level), 32'h1, "R9 level above");
    pop_status(32'h0012_2000, "R6 broadcast");
    chk(32'(st_level), 32'h1, "R9 level still above");
    pop_status(32'h4018_0400, "R6 multicast miss");
    chk(32'(st_level), 32'h0, "R9 level equal");
    pop_status(32'h0009_2000, "R6 bcast over mcast");
    pop_status(32'h0009_2000, "R10 empty pop holds");
    chk(32'(stat_words), 32'd0, "R10 count stays zero");
    st_thresh = 8'd0;
  endtask

  task automatic t_skip();
    pulse_dump();
    cfg_lead = 3'd3; cfg_align = 2'd1;
    push_pkt(8, 32'hF000_0000, 1'b0, 1'b0, 1'b0);
    push_pkt(4, 32'hF100_0000, 1'b0, 1'b0, 1'b0);
    chk(32'(data_words), 32'd5, "R7 before skip");
    rd_chk(32'h0, "R7 lead before skip");
    pulse_skip();
    chk(32'(data_words), 32'd2, "R7 skip in lead");
    chk(rd_data, 32'h0, "R7 skip leaves rd_data");
    cfg_lead = 3'd0; cfg_align = 2'd0;
    rd_chk(32'hF100_0000, "R7 next packet first");
    pulse_skip();
    chk(32'(data_words), 32'd0, "R7 skip mid data");
    push_pkt(8, 32'hF200_0000, 1'b0, 1'b0, 1'b0);
    push_pkt(4, 32'hF300_0000, 1'b0, 1'b0, 1'b0);
    pulse_skip();
    chk(32'(data_words), 32'd2, "R7 idle skip drops packet");
    chk(32'(rx_err), 32'h0, "R7 skip no error");
    rd_chk(32'hF300_0000, "R7 after idle skip");
    rd_chk(32'hF300_0001, "R7 after idle skip 2");
  endtask

  task automatic t_dump();
    pulse_dump();
    push_pkt(12, 32'h1100_0000, 1'b0, 1'b0, 1'b0);
    @(negedge clk); dump_req = 1'b1;
    @(negedge clk); dump_req = 1'b0;
    chk(32'(data_words), 32'd0, "R8 data emptied");
    chk(32'(stat_words), 32'd0, "R8 status emptied");
    rd_chk(32'h0, "R8 read after dump");
    chk(32'(rx_err), 32'h1, "R8 underflow after dump");
  endtask

  task automatic t_wrap();
    pulse_dump();
    cfg_lead = 3'd0; cfg_align = 2'd0;
    for (int p = 0; p < 6; p++) begin
      push_pkt(40, 32'h5000_0000 + 32'(p * 16), 1'b0, 1'b0, 1'b0);
      for (int i = 0; i < 11; i++) rd_chk(32'h5000_0000 + 32'(p * 16 + i), "R11 wrap order");
      pop_status(32'h002C_0000, "R11 wrap status");
    end
    chk(32'(data_words), 32'd0, "R11 drained");
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_align();
    t_status();
    t_skip();
    t_dump();
    t_wrap();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule